// File: doc/BRIEF.md
# Acquisition Link Control Sequencer

This block is the back-end controller of a serial acquisition link. It walks the link through its whole life cycle. First it proves the link is synchronised with a fixed test word. It then measures the round-trip delay by sending a marker that the front end echoes back. Next it switches to normal traffic and sends a one-word initialisation command to the remote digitiser. After that it waits, armed, for a trigger. Once triggered it captures every valid received word into a local capture buffer, until a stop command arrives or the buffer fills. After the stop it streams the stored words to the host side over a valid/ready interface.

The transmit word and the received word are parallel buses at the serialiser boundary. The whole block runs on one system clock, so the measured delay is a fixed number of cycles. The current phase is visible on a 3-bit output. The measured latency remains readable after bring-up, and the number of stored samples is reported.

Top module: `link_seq`

## Requirements
- R1: After reset the phase output is 0 (test mode). The transmit word is the test word 16'hA5C3, the latency-valid, error and full flags are low, and the dump stream is idle.
- R2: In test mode, each cycle with rx_valid high and rx_word equal to 16'hA5C3 adds one to a match run. A valid cycle with any other word clears the run, and cycles with rx_valid low leave it unchanged. The cycle that completes a run of 8 moves the phase to 1 (latency).
- R3: In the first latency-phase cycle the transmit word is the marker 16'h3C5A. If the marker comes back valid N cycles later (1 ≤ N ≤ 255), the latency output becomes N and latency-valid rises. Both then hold until reset.
- R4: If the marker has not returned by count 255, the error flag rises and the phase goes back to 0 with the match run cleared. A later successful measurement clears the error flag.
- R5: After a successful measurement the phase is 2 for exactly one cycle, transmitting the command word 16'hC0DE. The phase then becomes 3 (armed). In every later phase the transmit word is 16'h0000.
- R6: A trigger in phase 3 moves the phase to 4 (capture), clears the sample count and clears the full flag. A trigger in any other phase has no effect.
- R7: In phase 4, each cycle with rx_valid high stores rx_word at the next address, starting from 0, and adds one to the sample count output.
- R8: When the 1024th sample is stored, the phase becomes 5 (halted) and the full flag rises. Further valid words are not stored.
- R9: A stop in phase 4 or 5 moves the phase to 6 (dump). A stop in any other phase has no effect.
- R10: In phase 6 the stored samples leave in address order, one per cycle in which dump_valid and dump_ready are both high. While dump_valid is high and dump_ready is low, the data holds.
- R11: When all stored samples have left, including the case of zero samples, dump_done pulses high for one cycle. The phase returns to 3 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tx_word_o | output | 16 | Word handed to the serialiser |
| rx_valid_i | input | 1 | Received word is valid this cycle |
| rx_word_i | input | 16 | Word from the deserialiser |
| trig_i | input | 1 | Acquisition trigger |
| stop_i | input | 1 | Stop-acquisition command |
| phase_o | output | 3 | Current life-cycle phase (0 to 6) |
| lat_o | output | 8 | Measured round-trip latency in cycles |
| lat_valid_o | output | 1 | Latency value is valid |
| lat_err_o | output | 1 | Latency measurement timed out |
| full_o | output | 1 | Capture buffer filled before stop |
| sample_cnt_o | output | 11 | Number of samples stored |
| dump_data_o | output | 16 | Post-mortem stream data |
| dump_valid_o | output | 1 | Stream data valid |
| dump_ready_i | input | 1 | Host accepts stream data |
| dump_done_o | output | 1 | One-cycle pulse after the last streamed word |

## Verification
The assertions assume that rx_valid, rx_word, trig, stop and dump_ready are settled before each rising edge. They also assume that the marker word appears on the receive side only as the echo of the marker the block sent. The stimulus drives every input on the falling edge. During bring-up it models the front end as an exact echo of the transmit word after a fixed delay, and with the echo switched off the test and error words are applied directly. The test and marker words are never used as capture data while the block is in its first two phases.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
    typedef enum logic [2:0] {
        PH_TEST  = 3'd0,
        PH_LAT   = 3'd1,
        PH_INIT  = 3'd2,
        PH_ARMED = 3'd3,
        PH_CAPT  = 3'd4,
        PH_HALT  = 3'd5,
        PH_DUMP  = 3'd6
    } phase_e;
endpackage

// File: rtl/link_lock_det.sv
module link_lock_det #(
    parameter int          W       = 16,
    parameter int          RUN     = 8,
    parameter logic [W-1:0] PATTERN = 16'hA5C3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         vld_i,
    input  logic [W-1:0] word_i,
    output logic         hit_o
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] run_d, run_q;
    logic          match;

    assign match = (word_i == PATTERN);
    assign hit_o = !clear_i && vld_i && match && (run_q == CW'(RUN - 1));

    always_comb begin
        run_d = run_q;
        if (clear_i)
            run_d = '0;
        else if (vld_i)
            run_d = match ? run_q + 1'b1 : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) run_q <= '0;
        else         run_q <= run_d;
    end

    // R2: a wrong valid word restarts the run
    p_mismatch_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && !match) |=> (run_q == '0));
    // R2: idle cycles keep the run
    p_idle_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vld_i && !clear_i) |=> $stable(run_q));
endmodule

// File: rtl/link_cap_ram.sv
module link_cap_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/link_seq.sv
module link_seq
    import link_seq_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          LAT_W     = 8,
    parameter int          DEPTH     = 1024,
    parameter int          LOCK_RUN  = 8,
    parameter logic [15:0] TEST_WORD = 16'hA5C3,
    parameter logic [15:0] MARK_WORD = 16'h3C5A,
    parameter logic [15:0] INIT_WORD = 16'hC0DE,
    parameter logic [15:0] IDLE_WORD = 16'h0000,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [DATA_W-1:0] tx_word_o,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic              trig_i,
    input  logic              stop_i,
    output logic [2:0]        phase_o,
    output logic [LAT_W-1:0]  lat_o,
    output logic              lat_valid_o,
    output logic              lat_err_o,
    output logic              full_o,
    output logic [CW-1:0]     sample_cnt_o,
    output logic [DATA_W-1:0] dump_data_o,
    output logic              dump_valid_o,
    input  logic              dump_ready_i,
    output logic              dump_done_o
);
    typedef struct packed {
        phase_e           ph;
        logic [LAT_W-1:0] lcnt;
        logic [LAT_W-1:0] lat;
        logic             lat_ok;
        logic             err;
        logic [CW-1:0]    wcnt;
        logic [CW-1:0]    rptr;
        logic             full;
        logic             done;
    } seq_t;

    seq_t st_d, st_q;
    logic lock_hit, marker_hit, we, last_slot;

    link_lock_det #(
        .W(DATA_W), .RUN(LOCK_RUN), .PATTERN(TEST_WORD)
    ) lock_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (st_q.ph != PH_TEST),
        .vld_i   (rx_valid_i),
        .word_i  (rx_word_i),
        .hit_o   (lock_hit)
    );

    link_cap_ram #(
        .W(DATA_W), .DEPTH(DEPTH)
    ) ram_i (
        .clk_i   (clk_i),
        .we_i    (we),
        .waddr_i (st_q.wcnt[AW-1:0]),
        .wdata_i (rx_word_i),
        .raddr_i (st_q.rptr[AW-1:0]),
        .rdata_o (dump_data_o)
    );

    assign marker_hit = rx_valid_i && (rx_word_i == MARK_WORD) && (st_q.lcnt != '0);
    assign last_slot  = (st_q.wcnt == CW'(DEPTH - 1));

    always_comb begin
        case (st_q.ph)
            PH_TEST: tx_word_o = TEST_WORD;
            PH_LAT:  tx_word_o = (st_q.lcnt == '0) ? MARK_WORD : IDLE_WORD;
            PH_INIT: tx_word_o = INIT_WORD;
            default: tx_word_o = IDLE_WORD;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        we        = 1'b0;
        case (st_q.ph)
            PH_TEST: begin
                st_d.lcnt = '0;
                if (lock_hit) st_d.ph = PH_LAT;
            end
            PH_LAT: begin
                if (marker_hit) begin
                    st_d.lat    = st_q.lcnt;
                    st_d.lat_ok = 1'b1;
                    st_d.err    = 1'b0;
                    st_d.ph     = PH_INIT;
                end else if (st_q.lcnt == '1) begin
                    st_d.err  = 1'b1;
                    st_d.lcnt = '0;
                    st_d.ph   = PH_TEST;
                end else begin
                    st_d.lcnt = st_q.lcnt + 1'b1;
                end
            end
            PH_INIT: st_d.ph = PH_ARMED;
            PH_ARMED: begin
                if (trig_i) begin
                    st_d.ph   = PH_CAPT;
                    st_d.wcnt = '0;
                    st_d.full = 1'b0;
                end
            end
            PH_CAPT: begin
                if (rx_valid_i) begin
                    we        = 1'b1;
                    st_d.wcnt = st_q.wcnt + 1'b1;
                    if (last_slot) begin
                        st_d.full = 1'b1;
                        st_d.ph   = PH_HALT;
                    end
                end
                if (stop_i) begin
                    st_d.ph   = PH_DUMP;
                    st_d.rptr = '0;
                end
            end
            PH_HALT: begin
                if (stop_i) begin
                    st_d.ph   = PH_DUMP;
                    st_d.rptr = '0;
                end
            end
            PH_DUMP: begin
                if (st_q.rptr == st_q.wcnt) begin
                    st_d.ph   = PH_ARMED;
                    st_d.done = 1'b1;
                end else if (dump_ready_i) begin
                    st_d.rptr = st_q.rptr + 1'b1;
                end
            end
            default: st_d.ph = PH_TEST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{ph: PH_TEST, default: '0};
        else         st_q <= st_d;
    end

    assign phase_o      = st_q.ph;
    assign lat_o        = st_q.lat;
    assign lat_valid_o  = st_q.lat_ok;
    assign lat_err_o    = st_q.err;
    assign full_o       = st_q.full;
    assign sample_cnt_o = st_q.wcnt;
    assign dump_valid_o = (st_q.ph == PH_DUMP) && (st_q.rptr != st_q.wcnt);
    assign dump_done_o  = st_q.done;

    // R2: the latency phase is entered only from test mode
    p_lat_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_LAT) |-> ($past(st_q.ph) == PH_TEST || $past(st_q.ph) == PH_LAT));
    // R3: once measured, latency stays put
    p_lat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lat_valid_o |=> (lat_valid_o && $stable(lat_o)));
    // R4: timeout returns to test mode with the error flag
    p_timeout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_LAT && st_q.lcnt == '1 && !marker_hit) |=> (st_q.ph == PH_TEST && lat_err_o));
    // R5: the command phase lasts one cycle
    p_init_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_INIT) |=> (st_q.ph == PH_ARMED));
    // R8: no write beyond the last slot
    p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_CAPT) |-> (sample_cnt_o < CW'(DEPTH)));
    // R9: stop while armed is ignored
    p_stop_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_ARMED && stop_i && !trig_i) |=> (st_q.ph == PH_ARMED));
    // R10: stalled stream data holds
    p_dump_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dump_valid_o && !dump_ready_i) |=> (dump_valid_o && $stable(dump_data_o)));
    // R11: done is a single-cycle pulse landing in the armed phase
    p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dump_done_o |-> (st_q.ph == PH_ARMED && $past(st_q.ph) == PH_DUMP));
endmodule

// File: tb/link_seq_tb_top.sv
`timescale 1ns/1ps
module link_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] tx_word;
    logic        rx_valid;
    logic [15:0] rx_word;
    logic        trig, stop;
    logic [2:0]  phase;
    logic [7:0]  lat;
    logic        lat_valid, lat_err, full;
    logic [10:0] sample_cnt;
    logic [15:0] dump_data;
    logic        dump_valid, dump_ready, dump_done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit loop_en = 0;
    int loop_dly = 1;
    logic [15:0] hist [512];
    logic [15:0] exp_q [1024];

    // {echo delay, expect success, expected latency}
    localparam int VEC [6][3] = '{
        '{1, 1, 1}, '{3, 1, 3}, '{17, 1, 17},
        '{200, 1, 200}, '{255, 1, 255}, '{256, 0, 0}
    };

    always #2.5 clk = ~clk;

    link_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tx_word_o(tx_word),
        .rx_valid_i(rx_valid), .rx_word_i(rx_word),
        .trig_i(trig), .stop_i(stop), .phase_o(phase),
        .lat_o(lat), .lat_valid_o(lat_valid), .lat_err_o(lat_err),
        .full_o(full), .sample_cnt_o(sample_cnt),
        .dump_data_o(dump_data), .dump_valid_o(dump_valid),
        .dump_ready_i(dump_ready), .dump_done_o(dump_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        hist[cyc % 512] = tx_word;
        if (loop_en) begin
            if (cyc >= loop_dly) begin
                rx_word  = hist[(cyc - loop_dly) % 512];
                rx_valid = 1'b1;
            end else begin
                rx_valid = 1'b0;
            end
        end
        cyc++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_valid = 1'b0; rx_word = '0;
        trig = 1'b0; stop = 1'b0; dump_ready = 1'b0; loop_en = 0;
        for (int i = 0; i < 512; i++) hist[i] = '0;
        cyc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bring_up(input int dly);
        do_reset();
        loop_dly = dly; loop_en = 1;
        for (int k = 0; k < 2000 && phase != 3'd3; k++) step();
        loop_en = 0; rx_valid = 1'b0;
        check(phase == 3'd3, "R5 bring-up reaches armed", phase, 3);
    endtask

    task automatic drain(input int n, input bit stall, input string req);
        int idx = 0;
        bit seen = 0;
        for (int k = 0; k < 4 * n + 20; k++) begin
            dump_ready = stall ? ((k % 3) != 1) : 1'b1;
            if (dump_done) begin
                seen = 1;
                break;
            end
            if (dump_valid && dump_ready) begin
                check(dump_data == exp_q[idx], req, dump_data, exp_q[idx]);
                idx++;
            end
            step();
        end
        dump_ready = 1'b0;
        check(seen, "R11 done pulse seen", seen, 1);
        check(idx == n, "R11 word count before done", idx, n);
        check(phase == 3'd3, "R11 back to armed with done", phase, 3);
        step();
        check(!dump_done, "R11 done lasts one cycle", dump_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired (R1 run) act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        step();
        check(phase == 3'd0, "R1 phase after reset", phase, 0);
        check(tx_word == 16'hA5C3, "R1 tx test word", tx_word, 16'hA5C3);
        check(!lat_valid && !lat_err && !full, "R1 flags low", {lat_valid, lat_err, full}, 0);
        check(!dump_valid && !dump_done, "R1 stream idle", dump_valid, 0);

        // R6 trigger in test mode ignored
        trig = 1'b1; step(); trig = 1'b0; step();
        check(phase == 3'd0, "R6 trigger ignored in test mode", phase, 0);

        // R3 R4 R5 table of echo delays
        for (int v = 0; v < 6; v++) begin
            do_reset();
            loop_dly = VEC[v][0]; loop_en = 1;
            for (int k = 0; k < 3000 && phase != 3'd2 && !lat_err; k++) step();
            if (VEC[v][1] == 1) begin
                check(phase == 3'd2, "R5 command phase reached", phase, 2);
                check(tx_word == 16'hC0DE, "R5 command word", tx_word, 16'hC0DE);
                check(lat_valid && lat == 8'(VEC[v][2]), "R3 measured latency", lat, VEC[v][2]);
                step();
                check(phase == 3'd3, "R5 armed after one cycle", phase, 3);
                check(tx_word == 16'h0000, "R5 idle word when armed", tx_word, 0);
            end else begin
                check(lat_err && !lat_valid, "R4 timeout flags", {lat_err, lat_valid}, 2);
                check(phase == 3'd0, "R4 back to test mode", phase, 0);
            end
        end

        // R2 mismatch restarts the run, idle holds it
        do_reset();
        for (int i = 0; i < 7; i++) begin rx_valid = 1'b1; rx_word = 16'hA5C3; step(); end
        rx_word = 16'h1234; step();
        for (int i = 0; i < 7; i++) begin rx_word = 16'hA5C3; step(); end
        rx_valid = 1'b0; step();
        check(phase == 3'd0, "R2 no lock after broken run", phase, 0);
        rx_valid = 1'b1; rx_word = 16'hA5C3; step();
        rx_valid = 1'b0;
        check(phase == 3'd1, "R2 lock after 8 in a row", phase, 1);
        check(tx_word == 16'h3C5A, "R3 marker sent first", tx_word, 16'h3C5A);

        // R4 timeout then recovery
        repeat (255) step();
        check(phase == 3'd1, "R4 still measuring at 255", phase, 1);
        step();
        check(phase == 3'd0 && lat_err, "R4 timeout to test mode", phase, 0);
        loop_dly = 9; loop_en = 1;
        for (int k = 0; k < 2000 && phase != 3'd3; k++) step();
        loop_en = 0; rx_valid = 1'b0;
        check(lat == 8'd9 && lat_valid, "R3 latency after retry", lat, 9);
        check(!lat_err, "R4 error cleared by success", lat_err, 0);

        // R9 stop in armed ignored
        stop = 1'b1; step(); stop = 1'b0; step();
        check(phase == 3'd3, "R9 stop ignored when armed", phase, 3);

        // R6 R7 R10 capture with gaps and an extra trigger
        trig = 1'b1; step(); trig = 1'b0;
        check(phase == 3'd4 && sample_cnt == 0, "R6 trigger starts capture", phase, 4);
        for (int i = 0; i < 5; i++) begin
            exp_q[i] = 16'h0100 + 16'(i * 7);
            rx_valid = 1'b1; rx_word = exp_q[i]; step();
            rx_valid = 1'b0;
            if (i == 2) begin trig = 1'b1; step(); trig = 1'b0; end
            else step();
        end
        check(sample_cnt == 5, "R7 sample count with gaps", sample_cnt, 5);
        check(phase == 3'd4, "R6 trigger ignored in capture", phase, 4);
        stop = 1'b1; step(); stop = 1'b0;
        check(phase == 3'd6, "R9 stop starts dump", phase, 6);
        drain(5, 1'b1, "R10 stalled dump data order");
        check(lat == 8'd9 && lat_valid, "R3 latency still held", lat, 9);

        // R11 zero-sample dump
        trig = 1'b1; step(); trig = 1'b0;
        stop = 1'b1; step(); stop = 1'b0;
        check(phase == 3'd6 && !dump_valid, "R11 empty dump no data", dump_valid, 0);
        drain(0, 1'b0, "R10 empty dump");

        // R8 fill the buffer
        trig = 1'b1; step(); trig = 1'b0;
        for (int i = 0; i < 1024; i++) begin
            exp_q[i] = 16'(i ^ 16'h5500);
            rx_valid = 1'b1; rx_word = exp_q[i]; step();
        end
        check(phase == 3'd5 && full, "R8 halt and full flag", phase, 5);
        check(sample_cnt == 11'd1024, "R8 count at depth", sample_cnt, 1024);
        rx_word = 16'hFFFF; step(); rx_valid = 1'b0;
        check(sample_cnt == 11'd1024, "R8 extra word not stored", sample_cnt, 1024);
        stop = 1'b1; step(); stop = 1'b0;
        check(phase == 3'd6, "R9 stop from halted", phase, 6);
        drain(1024, 1'b0, "R10 full dump data order");
        check(full, "R8 full held until next trigger", full, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule